// File: doc/BRIEF.md
# Five-Class Memory Port Arbiter

This block sits between a Harvard-style processor core and one shared memory or peripheral port. The core has five request classes: data write, program write, data read, program read and instruction fetch. Each class has its own request line and address, and the two write classes also carry write data. In every cycle the arbiter grants the port to one requester under a fixed order. Writes win over reads, and reads win over fetches. The access of the winning class is performed on a single-cycle memory model. One cycle later that class receives a done pulse, and for read-type classes it also receives the read data.

The program side has a 22-bit address. It is zero-extended into the shared 32-bit address space, so program-side and data-side accesses to the same numeric address reach the same word. Two pairings of classes are illegal in the same cycle: both write classes together, and program read together with instruction fetch. When either pairing appears, the arbiter serves the higher-ranked member of the pair and sets a sticky error bit for that rule. The error bit stays set until reset.

Top module: `mbus_arbiter`

## Requirements
- R1: The grant vector `gnt_o` (bit 0 data write, bit 1 program write, bit 2 data read, bit 3 program read, bit 4 instruction fetch) is one-hot or zero. In the same cycle it selects the requesting class with the lowest bit index, so the order is data write > program write > data read > program read > fetch.
- R2: While `rst` is high, or while no class requests, `gnt_o` is zero.
- R3: `done_o` equals the `gnt_o` of the previous cycle and is zero in the first cycle after reset.
- R4: A granted write stores its 32-bit data at its address. A read-type grant (data read, program read or fetch) returns the stored word on `rdata_o` in the next cycle.
- R5: A program-side address is zero-extended to 32 bits. A word written by either write class can be read back by any read class at the same numeric address.
- R6: A data write and a program write requested in the same cycle set `err_o[0]` from the next cycle. The data write is served first.
- R7: A program read and a fetch requested in the same cycle set `err_o[1]` from the next cycle. The program read is served first.
- R8: Both error bits are sticky and clear only on reset. Reset also clears `done_o` and `rdata_o`.
- R9: `rdata_o` keeps its value in every cycle that follows a cycle with no read-type grant.
- R10: The memory decodes only the low `MEM_AW` address bits (default 6, so 64 words). An access whose upper address bits are not all zero still completes with a done pulse, but a write to it is dropped and a read from it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dw_req | input | 1 | Data write request |
| dw_addr | input | 32 | Data write address |
| dw_data | input | 32 | Data write data |
| pw_req | input | 1 | Program write request |
| pw_addr | input | 22 | Program write address |
| pw_data | input | 32 | Program write data |
| dr_req | input | 1 | Data read request |
| dr_addr | input | 32 | Data read address |
| pr_req | input | 1 | Program read request |
| pr_addr | input | 22 | Program read address |
| if_req | input | 1 | Instruction fetch request |
| if_addr | input | 22 | Instruction fetch address |
| gnt_o | output | 5 | One-hot grant, bit order as in R1 |
| done_o | output | 5 | Completion pulse, one cycle after grant |
| rdata_o | output | 32 | Read data of the last read-type grant |
| err_o | output | 2 | Sticky rule violations: bit 0 write pair, bit 1 program read/fetch pair |

## Verification
The checker assumes that a read-side class which loses arbitration keeps its request and address unchanged until it is granted. The bench respects this by design. In each sweep pattern it raises a set of requests, and it drops a request only in the cycle after that request has been granted. The sweep covers all 32 request patterns, the forbidden pairs included. Each pattern starts from reset, so the expected error bits depend only on that pattern. The data tests issue one request at a time, except where the forbidden pairs are exercised on purpose.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int BUS_AW  = 32;
    localparam int BUS_DW  = 32;
    localparam int PROG_AW = 22;
    localparam int NCLS    = 5;

    // Class index doubles as rank: lower index wins.
    typedef enum logic [2:0] {
        CLS_DWR = 3'd0,
        CLS_PWR = 3'd1,
        CLS_DRD = 3'd2,
        CLS_PRD = 3'd3,
        CLS_FET = 3'd4
    } cls_e;

    typedef struct packed {
        logic              we;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] wdata;
    } acc_t;

    function automatic logic [BUS_AW-1:0] zext_prog(input logic [PROG_AW-1:0] a);
        return {{(BUS_AW-PROG_AW){1'b0}}, a};
    endfunction

    function automatic acc_t mk_acc(input logic we,
                                    input logic [BUS_AW-1:0] addr,
                                    input logic [BUS_DW-1:0] wdata);
        acc_t r;
        r.we    = we;
        r.addr  = addr;
        r.wdata = wdata;
        return r;
    endfunction

endpackage

// File: rtl/mbus_prio_pick.sv
module mbus_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_rank
        assign seen[i+1] = seen[i] | req[i];
        assign gnt[i]    = req[i] & ~seen[i];
    end

endmodule

// File: rtl/mbus_conflict_chk.sv
module mbus_conflict_chk
    import mbus_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NCLS-1:0] req,
    output logic [1:0]      err
);
    logic [1:0] hit;

    always_comb begin
        hit[0] = req[CLS_DWR] & req[CLS_PWR];
        hit[1] = req[CLS_PRD] & req[CLS_FET];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err <= '0;
        end else begin
            err <= err | hit;
        end
    end

endmodule

// File: rtl/mbus_mem_model.sv
module mbus_mem_model
    import mbus_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              we,
    input  logic [BUS_AW-1:0] addr,
    input  logic [BUS_DW-1:0] wdata,
    output logic [BUS_DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [BUS_DW-1:0] mem [DEPTH];
    logic              in_range;
    logic [AW-1:0]     idx;

    assign in_range = ~|addr[BUS_AW-1:AW];
    assign idx      = addr[AW-1:0];

    always_ff @(posedge clk) begin
        if (en && we && in_range) begin
            mem[idx] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (en && !we) begin
            rdata <= in_range ? mem[idx] : '0;
        end
    end

endmodule

// File: rtl/mbus_arbiter.sv
module mbus_arbiter
    import mbus_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dw_req,
    input  logic [BUS_AW-1:0]  dw_addr,
    input  logic [BUS_DW-1:0]  dw_data,
    input  logic               pw_req,
    input  logic [PROG_AW-1:0] pw_addr,
    input  logic [BUS_DW-1:0]  pw_data,
    input  logic               dr_req,
    input  logic [BUS_AW-1:0]  dr_addr,
    input  logic               pr_req,
    input  logic [PROG_AW-1:0] pr_addr,
    input  logic               if_req,
    input  logic [PROG_AW-1:0] if_addr,
    output logic [NCLS-1:0]    gnt_o,
    output logic [NCLS-1:0]    done_o,
    output logic [BUS_DW-1:0]  rdata_o,
    output logic [1:0]         err_o
);
    logic [NCLS-1:0] req_raw;
    logic [NCLS-1:0] req_live;
    logic [NCLS-1:0] pick;
    acc_t            acc [NCLS];
    acc_t            sel;

    assign req_raw  = {if_req, pr_req, dr_req, pw_req, dw_req};
    assign req_live = rst ? '0 : req_raw;

    always_comb begin
        acc[CLS_DWR] = mk_acc(1'b1, dw_addr,            dw_data);
        acc[CLS_PWR] = mk_acc(1'b1, zext_prog(pw_addr), pw_data);
        acc[CLS_DRD] = mk_acc(1'b0, dr_addr,            '0);
        acc[CLS_PRD] = mk_acc(1'b0, zext_prog(pr_addr), '0);
        acc[CLS_FET] = mk_acc(1'b0, zext_prog(if_addr), '0);
    end

    mbus_prio_pick #(.N(NCLS)) u_pick (
        .req (req_live),
        .gnt (pick)
    );

    // One-hot select: OR of masked entries.
    always_comb begin
        sel = '0;
        for (int i = 0; i < NCLS; i++) begin
            if (pick[i]) begin
                sel = sel | acc[i];
            end
        end
    end

    mbus_mem_model #(.AW(MEM_AW)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .en    (|pick),
        .we    (sel.we),
        .addr  (sel.addr),
        .wdata (sel.wdata),
        .rdata (rdata_o)
    );

    mbus_conflict_chk u_conf (
        .clk (clk),
        .rst (rst),
        .req (req_live),
        .err (err_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o <= '0;
        end else begin
            done_o <= pick;
        end
    end

    assign gnt_o = pick;

endmodule

// File: rtl/mbus_arbiter_chk.sv
module mbus_arbiter_chk
    import mbus_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               dw_req,
    input logic               pw_req,
    input logic               dr_req,
    input logic [BUS_AW-1:0]  dr_addr,
    input logic               pr_req,
    input logic [PROG_AW-1:0] pr_addr,
    input logic               if_req,
    input logic [PROG_AW-1:0] if_addr,
    input logic [NCLS-1:0]    gnt_o,
    input logic [NCLS-1:0]    done_o,
    input logic [BUS_DW-1:0]  rdata_o,
    input logic [1:0]         err_o
);
    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o)); // R1
    AST_DW_WINS: assert property (@(posedge clk) disable iff (rst)
        dw_req |-> gnt_o[CLS_DWR]); // R1
    AST_FETCH_LAST: assert property (@(posedge clk) disable iff (rst)
        gnt_o[CLS_FET] |-> !(dw_req || pw_req || dr_req || pr_req)); // R1
    AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (rst)
        !(dw_req || pw_req || dr_req || pr_req || if_req) |-> gnt_o == '0); // R2
    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !rst |=> done_o == $past(gnt_o)); // R3
    AST_WPAIR_ERR: assert property (@(posedge clk) disable iff (rst)
        dw_req && pw_req |=> err_o[0]); // R6
    AST_RPAIR_ERR: assert property (@(posedge clk) disable iff (rst)
        pr_req && if_req |=> err_o[1]); // R7
    AST_ERR0_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_o[0] |=> err_o[0]); // R8
    AST_ERR1_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_o[1] |=> err_o[1]); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(|gnt_o[CLS_FET:CLS_DRD]) |=> $stable(rdata_o)); // R9
    AST_DR_HOLD: assert property (@(posedge clk) disable iff (rst)
        dr_req && !gnt_o[CLS_DRD] |=> dr_req && $stable(dr_addr)); // R1
    AST_PR_HOLD: assert property (@(posedge clk) disable iff (rst)
        pr_req && !gnt_o[CLS_PRD] |=> pr_req && $stable(pr_addr)); // R7
    AST_IF_HOLD: assert property (@(posedge clk) disable iff (rst)
        if_req && !gnt_o[CLS_FET] |=> if_req && $stable(if_addr)); // R7
endmodule

bind mbus_arbiter mbus_arbiter_chk u_chk (.*);

// File: tb/mbus_arbiter_bench.sv
`timescale 1ns/1ps
module mbus_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        dw_req = 0, pw_req = 0, dr_req = 0, pr_req = 0, if_req = 0;
    logic [31:0] dw_addr = 0, dw_data = 0, pw_data = 0, dr_addr = 0;
    logic [21:0] pw_addr = 0, pr_addr = 0, if_addr = 0;
    logic [4:0]  gnt_o, done_o;
    logic [31:0] rdata_o;
    logic [1:0]  err_o;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mbus_arbiter u_mbus_arbiter (
        .clk(clk), .rst(rst),
        .dw_req(dw_req), .dw_addr(dw_addr), .dw_data(dw_data),
        .pw_req(pw_req), .pw_addr(pw_addr), .pw_data(pw_data),
        .dr_req(dr_req), .dr_addr(dr_addr),
        .pr_req(pr_req), .pr_addr(pr_addr),
        .if_req(if_req), .if_addr(if_addr),
        .gnt_o(gnt_o), .done_o(done_o), .rdata_o(rdata_o), .err_o(err_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_req(input logic [4:0] r);
        {if_req, pr_req, dr_req, pw_req, dw_req} = r;
    endtask

    // One cycle: drive requests, check grant, check done after the edge.
    task automatic cyc(input logic [4:0] r, input logic [4:0] expg, input string tag);
        @(negedge clk);
        set_req(r);
        #1 chk({tag, " R1 grant"}, {27'd0, gnt_o}, {27'd0, expg});
        @(posedge clk);
        #1 chk({tag, " R3 done"}, {27'd0, done_o}, {27'd0, expg});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        set_req(5'b11111);
        #1 chk("R2 no grant in reset", {27'd0, gnt_o}, 32'd0);
        @(posedge clk);
        #1;
        chk("R8 reset done", {27'd0, done_o}, 32'd0);
        chk("R8 reset err", {30'd0, err_o}, 32'd0);
        chk("R8 reset rdata", rdata_o, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        set_req(5'b0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // Sweep every request pattern; drop each request after its grant.
        for (int p = 0; p < 32; p++) begin
            logic [4:0] rem;
            logic [4:0] eg;
            logic [1:0] ee;
            do_reset();
            rem = p[4:0];
            ee  = {rem[3] & rem[4], rem[0] & rem[1]};
            dw_addr = 32'd40; pw_addr = 22'd41; dr_addr = 32'd40;
            pr_addr = 22'd41; if_addr = 22'd42;
            dw_data = 32'h1000_0000 + p; pw_data = 32'h2000_0000 + p;
            while (rem != 5'd0) begin
                eg = rem & (~rem + 5'd1);
                cyc(rem, eg, "sweep");
                rem = rem & ~eg;
            end
            cyc(5'd0, 5'd0, "sweep idle R2");
            chk("R6 R7 sweep err", {30'd0, err_o}, {30'd0, ee});
        end

        do_reset();
        // R4 R5: data write, then program read at the same address.
        dw_addr = 32'd5; dw_data = 32'hA5A5_0001;
        cyc(5'b00001, 5'b00001, "R4 dwrite");
        pr_addr = 22'd5;
        cyc(5'b01000, 5'b01000, "R5 pread");
        chk("R5 pread data", rdata_o, 32'hA5A5_0001);

        pw_addr = 22'd9; pw_data = 32'h0BAD_0009;
        cyc(5'b00010, 5'b00010, "R5 pwrite");
        dr_addr = 32'd9;
        cyc(5'b00100, 5'b00100, "R5 dread");
        chk("R5 dread data", rdata_o, 32'h0BAD_0009);
        if_addr = 22'd9;
        cyc(5'b10000, 5'b10000, "R4 fetch");
        chk("R4 fetch data", rdata_o, 32'h0BAD_0009);

        // R9: write does not disturb rdata.
        dw_addr = 32'd9; dw_data = 32'h7777_7777;
        cyc(5'b00001, 5'b00001, "R9 write");
        chk("R9 rdata held", rdata_o, 32'h0BAD_0009);
        cyc(5'd0, 5'd0, "R9 idle");
        chk("R9 rdata held idle", rdata_o, 32'h0BAD_0009);
        dr_addr = 32'd9;
        cyc(5'b00100, 5'b00100, "R4 reread");
        chk("R4 overwrite data", rdata_o, 32'h7777_7777);

        // R10: out-of-range write dropped, out-of-range read returns zero.
        dw_addr = 32'h0000_0049; dw_data = 32'hDEAD_BEEF;
        cyc(5'b00001, 5'b00001, "R10 far write");
        dr_addr = 32'd9;
        cyc(5'b00100, 5'b00100, "R10 alias read");
        chk("R10 no alias write", rdata_o, 32'h7777_7777);
        dr_addr = 32'h8000_0009;
        cyc(5'b00100, 5'b00100, "R10 far read");
        chk("R10 far read zero", rdata_o, 32'd0);

        // R6: both writes together; data write first, then program write.
        dw_addr = 32'd12; dw_data = 32'h0000_C0DE;
        pw_addr = 22'd13; pw_data = 32'h0000_BEEF;
        cyc(5'b00011, 5'b00001, "R6 pair");
        chk("R6 err set", {30'd0, err_o}, 32'd1);
        cyc(5'b00010, 5'b00010, "R6 pw served");
        dr_addr = 32'd12;
        cyc(5'b00100, 5'b00100, "R6 rd12");
        chk("R6 dw data", rdata_o, 32'h0000_C0DE);
        dr_addr = 32'd13;
        cyc(5'b00100, 5'b00100, "R6 rd13");
        chk("R6 pw data", rdata_o, 32'h0000_BEEF);

        // R7: program read and fetch together.
        pr_addr = 22'd12; if_addr = 22'd13;
        cyc(5'b11000, 5'b01000, "R7 pair");
        chk("R7 pread data", rdata_o, 32'h0000_C0DE);
        chk("R7 err set", {30'd0, err_o}, 32'd3);
        cyc(5'b10000, 5'b10000, "R7 fetch served");
        chk("R7 fetch data", rdata_o, 32'h0000_BEEF);

        // R8: sticky across idle cycles, cleared by reset.
        for (int k = 0; k < 4; k++) cyc(5'd0, 5'd0, "R8 idle");
        chk("R8 err sticky", {30'd0, err_o}, 32'd3);
        do_reset();

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule